// File: doc/BRIEF.md
# Interval Timer with Seconds/Nanoseconds Clock

This peripheral sits on a simple 32-bit register bus and provides two independent time services. The first is a programmable interval interrupt source. Software writes a reload interval and a control word. The control word holds the run bit together with the interrupt number and priority that the timer presents to the interrupt controller alongside each one-cycle request pulse. The second is a free-running wall clock. It keeps a nanoseconds field and a 64-bit seconds count, and every clock it advances by a fixed clock period in nanoseconds. That period can be read back, so software can derive the tick rate as 1e9 divided by it.

Software restarts the interval source in three steps: it writes zero to the control word, then the interval, then the full control word. The clock is read without locking. The seconds-low word is read, then nanoseconds, then seconds-low again, and the read is repeated until both seconds-low values agree. For that to work, the nanoseconds wrap and the seconds carry must land on the same clock edge.

A parameter selects how the interrupt number is presented. The plain mapping passes the programmed number and priority through. The compact mapping confines the number to the range 64 to 127 and folds the priority into it.

Top module: `interval_tod_timer`

## Requirements
- R1: After reset the control word, interval, live count, nanoseconds and both seconds words read 0, and `irq_pulse`, `irq_num` and `irq_prio` are 0.
- R2: Register offsets are 0x00 control, 0x10 interval, 0x14 live count, 0x18 clock period, 0x20 seconds high, 0x24 seconds low and 0x28 nanoseconds. In the control word, bit 26 is run, bits 23:20 are priority and bits 19:12 are interrupt number, and all other control bits read 0. Read data appears on `bus_rdata` the cycle after `bus_rd`. Unmapped offsets read 0.
- R3: With run set and an interval T of at least 1, `irq_pulse` is high for one cycle every T cycles. The first pulse is high in the T-th cycle after the edge that wrote the run bit.
- R4: The live count register reads the current count, which steps 0, 1, …, T-1 and then returns to 0.
- R5: While the run bit is 0, no pulse is produced and the live count reads 0.
- R6: An interval of 0 produces no pulse, even with run set.
- R7: During a pulse, `irq_prio` carries the programmed priority. With the plain mapping, `irq_num` carries the programmed number. With the compact mapping, `irq_num` = 0x40 | (number & 0x3F) | (priority << 2). Outside a pulse both outputs are 0.
- R8: The clock-period register reads the PERIOD_NS parameter (20 by default). Writes to it have no effect.
- R9: The nanoseconds field grows by PERIOD_NS on every clock. When the sum reaches 1,000,000,000 or more, 1,000,000,000 is subtracted.
- R10: The wrap of R9 adds one to the 64-bit seconds count on the same edge, and a carry out of seconds-low ripples into seconds-high.
- R11: Writes to seconds-high, seconds-low or nanoseconds load that word with the written value on that edge, in place of its advanced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_num | output | 8 | Interrupt number presented with the request |
| irq_prio | output | 4 | Interrupt priority presented with the request |

## Verification
The bench drives the nanoseconds field to just below one second and reads it back every cycle across the wrap. A design that subtracted the wrong amount, or carried into seconds one edge late, would show a nanoseconds value that was not reduced by exactly 1e9, or a seconds-low value that was stale when the nanoseconds had already wrapped. Seconds-low is preset to all ones so that the carry must reach seconds-high; a 32-bit carry chain would leave seconds-high unchanged. The interval tests record the exact cycle of every pulse under a fixed interval, with run cleared, and with a zero interval. An off-by-one reload would shift the pulse train, and a zero interval handled as "always due" would flood pulses. The compact mapping is checked against the plain one using a number whose upper two bits are set; this exposes any design that forwards those bits or drops the folded priority.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Register offsets (byte addresses as seen by software)
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_THR    = 'h10;
  localparam int OFS_COUNT  = 'h14;
  localparam int OFS_PERIOD = 'h18;
  localparam int OFS_SECHI  = 'h20;
  localparam int OFS_SECLO  = 'h24;
  localparam int OFS_NSEC   = 'h28;

  // Control word field placement (decoded by software drivers)
  localparam int RUN_BIT  = 26;
  localparam int PRIO_LSB = 20;
  localparam int NUM_LSB  = 12;

  localparam int BUS_W    = 32;
  localparam int SEC_W    = 64;
  localparam longint NS_PER_SEC = 1000000000;
endpackage

// File: rtl/interval_gen.sv
module interval_gen #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             due
);
  logic [CNT_W:0] next_cnt;

  assign next_cnt = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
  // Reload on reaching or passing the limit, so a lowered limit cannot strand the count
  assign due = run && (limit != '0) && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run || limit == '0) begin
      count <= '0;
    end else if (due) begin
      count <= '0;
    end else begin
      count <= next_cnt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/irq_encode.sv
module irq_encode #(
  parameter bit COMPACT = 1'b1,
  parameter int NUM_W   = 8,
  parameter int PRIO_W  = 4
) (
  input  logic [NUM_W-1:0]  num_in,
  input  logic [PRIO_W-1:0] prio_in,
  output logic [NUM_W-1:0]  num_out
);
  localparam int LOW_W = NUM_W - 2;
  localparam logic [NUM_W-1:0] LOW_MASK = NUM_W'((1 << LOW_W) - 1);
  localparam logic [NUM_W-1:0] BASE     = NUM_W'(1 << LOW_W);

  generate
    if (COMPACT) begin : g_compact
      // Upper two bits forced to 01; priority folded in above bit 1
      assign num_out = BASE | (num_in & LOW_MASK) | (NUM_W'(prio_in) << 2);
    end else begin : g_plain
      assign num_out = num_in;
    end
  endgenerate
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int     NS_W      = 32,
  parameter int     SEC_W     = 64,
  parameter int     PERIOD_NS = 20,
  parameter longint ONE_SEC   = 1000000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_hi,
  input  logic             ld_lo,
  input  logic             ld_ns,
  input  logic [31:0]      wdata,
  output logic [NS_W-1:0]  nsec,
  output logic [SEC_W-1:0] secs
);
  localparam logic [NS_W:0] LIM  = (NS_W+1)'(ONE_SEC);
  localparam logic [NS_W:0] STEP = (NS_W+1)'(PERIOD_NS);
  localparam int HALF = SEC_W / 2;

  logic [NS_W:0]    ns_sum;
  logic             wrap;
  logic [NS_W-1:0]  ns_nxt;
  logic [SEC_W-1:0] sec_nxt;

  assign ns_sum = {1'b0, nsec} + STEP;
  assign wrap   = ns_sum >= LIM;

  always_comb begin
    ns_nxt  = wrap ? NS_W'(ns_sum - LIM) : ns_sum[NS_W-1:0];
    sec_nxt = secs + SEC_W'(wrap);
    if (ld_ns) ns_nxt = NS_W'(wdata);
    if (ld_hi) sec_nxt[SEC_W-1:HALF] = HALF'(wdata);
    if (ld_lo) sec_nxt[HALF-1:0]     = HALF'(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nsec <= '0;
      secs <= '0;
    end else begin
      nsec <= ns_nxt;
      secs <= sec_nxt;
    end
  end
endmodule

// File: rtl/interval_tod_timer.sv
module interval_tod_timer
  import timer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 32,
  parameter int NUM_W     = 8,
  parameter int PRIO_W    = 4,
  parameter int PERIOD_NS = 20,
  parameter bit COMPACT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_pulse,
  output logic [NUM_W-1:0]  irq_num,
  output logic [PRIO_W-1:0] irq_prio
);
  localparam int NS_W = 32;
  localparam int HALF = SEC_W / 2;

  logic              run_q;
  logic [PRIO_W-1:0] prio_q;
  logic [NUM_W-1:0]  num_q;
  logic [CNT_W-1:0]  thr_q;
  logic [CNT_W-1:0]  cnt_w;
  logic              due_w;
  logic [NUM_W-1:0]  num_enc;
  logic [NS_W-1:0]   ns_w;
  logic [SEC_W-1:0]  sec_w;
  logic              wr_ctrl, wr_thr, wr_hi, wr_lo, wr_ns;
  logic [BUS_W-1:0]  ctrl_word;

  assign wr_ctrl = bus_wr && bus_addr == ADDR_W'(OFS_CTRL);
  assign wr_thr  = bus_wr && bus_addr == ADDR_W'(OFS_THR);
  assign wr_hi   = bus_wr && bus_addr == ADDR_W'(OFS_SECHI);
  assign wr_lo   = bus_wr && bus_addr == ADDR_W'(OFS_SECLO);
  assign wr_ns   = bus_wr && bus_addr == ADDR_W'(OFS_NSEC);

  assign ctrl_word = (BUS_W'(run_q)  << RUN_BIT)
                   | (BUS_W'(prio_q) << PRIO_LSB)
                   | (BUS_W'(num_q)  << NUM_LSB);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      prio_q <= '0;
      num_q  <= '0;
      thr_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= bus_wdata[RUN_BIT];
        prio_q <= bus_wdata[PRIO_LSB +: PRIO_W];
        num_q  <= bus_wdata[NUM_LSB +: NUM_W];
      end
      if (wr_thr) thr_q <= CNT_W'(bus_wdata);
    end
  end

  interval_gen #(.CNT_W(CNT_W)) u_int (
    .clk   (clk),
    .rst   (rst),
    .run   (run_q),
    .limit (thr_q),
    .count (cnt_w),
    .due   (due_w)
  );

  irq_encode #(.COMPACT(COMPACT), .NUM_W(NUM_W), .PRIO_W(PRIO_W)) u_enc (
    .num_in  (num_q),
    .prio_in (prio_q),
    .num_out (num_enc)
  );

  tod_counter #(
    .NS_W(NS_W), .SEC_W(SEC_W), .PERIOD_NS(PERIOD_NS), .ONE_SEC(NS_PER_SEC)
  ) u_tod (
    .clk   (clk),
    .rst   (rst),
    .ld_hi (wr_hi),
    .ld_lo (wr_lo),
    .ld_ns (wr_ns),
    .wdata (bus_wdata),
    .nsec  (ns_w),
    .secs  (sec_w)
  );

  // Registered interrupt request: number and priority travel with the pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse <= 1'b0;
      irq_num   <= '0;
      irq_prio  <= '0;
    end else begin
      irq_pulse <= due_w;
      irq_num   <= due_w ? num_enc : '0;
      irq_prio  <= due_w ? prio_q  : '0;
    end
  end

  // Registered read port, one cycle of latency
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFS_CTRL):   bus_rdata <= ctrl_word;
        ADDR_W'(OFS_THR):    bus_rdata <= BUS_W'(thr_q);
        ADDR_W'(OFS_COUNT):  bus_rdata <= BUS_W'(cnt_w);
        ADDR_W'(OFS_PERIOD): bus_rdata <= BUS_W'(PERIOD_NS);
        ADDR_W'(OFS_SECHI):  bus_rdata <= BUS_W'(sec_w[SEC_W-1:HALF]);
        ADDR_W'(OFS_SECLO):  bus_rdata <= BUS_W'(sec_w[HALF-1:0]);
        ADDR_W'(OFS_NSEC):   bus_rdata <= BUS_W'(ns_w);
        default:             bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/timer_sva.sv
module timer_sva
  import timer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 32,
  parameter int NUM_W     = 8,
  parameter int PERIOD_NS = 20,
  parameter bit COMPACT   = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              run_q,
  input logic [CNT_W-1:0]  thr_q,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [31:0]       ns_w,
  input logic [63:0]       sec_w,
  input logic              irq_pulse,
  input logic [NUM_W-1:0]  irq_num
);
  logic tod_wr, thr_wr, ns_wr, near_wrap;
  assign ns_wr  = bus_wr && bus_addr == ADDR_W'(OFS_NSEC);
  assign tod_wr = ns_wr || (bus_wr && (bus_addr == ADDR_W'(OFS_SECHI) ||
                                       bus_addr == ADDR_W'(OFS_SECLO)));
  assign thr_wr = bus_wr && bus_addr == ADDR_W'(OFS_THR);
  assign near_wrap = ({1'b0, ns_w} + 33'(PERIOD_NS)) >= 33'(NS_PER_SEC);

  p_quiet_stopped_r5: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !irq_pulse);

  p_quiet_zero_limit_r6: assert property (@(posedge clk) disable iff (rst)
    thr_q == '0 |=> !irq_pulse);

  p_count_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    (run_q && thr_q != '0 && !thr_wr) |=> cnt_w < thr_q);

  p_ns_step_r9: assert property (@(posedge clk) disable iff (rst)
    !ns_wr |=> (ns_w == $past(ns_w) + 32'(PERIOD_NS)) ||
               (ns_w == $past(ns_w) + 32'(PERIOD_NS) - 32'(NS_PER_SEC)));

  p_carry_same_edge_r10: assert property (@(posedge clk) disable iff (rst)
    (!tod_wr && near_wrap) |=> sec_w == $past(sec_w) + 64'd1);

  generate
    if (COMPACT) begin : g_cmp
      p_num_window_r7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> irq_num[NUM_W-1 -: 2] == 2'b01);
    end
  endgenerate
endmodule

bind interval_tod_timer timer_sva #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_W(NUM_W),
  .PERIOD_NS(PERIOD_NS), .COMPACT(COMPACT)
) u_sva (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .run_q(run_q), .thr_q(thr_q), .cnt_w(cnt_w), .ns_w(ns_w), .sec_w(sec_w),
  .irq_pulse(irq_pulse), .irq_num(irq_num)
);

// File: tb/tb_interval_tod_timer.sv
`timescale 1ns/1ps
module tb_interval_tod_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_c, rdata_p;
  logic        pulse_c, pulse_p;
  logic [7:0]  num_c, num_p;
  logic [3:0]  prio_c, prio_p;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  interval_tod_timer #(.COMPACT(1'b1)) dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_c), .irq_pulse(pulse_c),
    .irq_num(num_c), .irq_prio(prio_c));

  interval_tod_timer #(.COMPACT(1'b0)) dut_plain (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_p), .irq_pulse(pulse_p),
    .irq_num(num_p), .irq_prio(prio_p));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Both tasks are entered at a falling edge and return at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rdata_c;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(pulse_c == 0 && num_c == 0 && prio_c == 0, "R1", "irq outputs", {pulse_c, num_c, prio_c}, 0);
    rd(8'h00, v); check(v == 0, "R1", "ctrl", v, 0);
    rd(8'h10, v); check(v == 0, "R1", "interval", v, 0);
    rd(8'h14, v); check(v == 0, "R1", "count", v, 0);
    rd(8'h20, v); check(v == 0, "R1", "seconds high", v, 0);
    rd(8'h24, v); check(v == 0, "R1", "seconds low", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check(v == 32'h04FF_F000, "R2", "ctrl field mask", v, 32'h04FF_F000);
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, v); check(v == 32'h1234_5678, "R2", "interval readback", v, 32'h1234_5678);
    rd(8'h04, v); check(v == 0, "R2", "unmapped offset", v, 0);
    wr(8'h18, 32'h55);
    rd(8'h18, v); check(v == 20, "R8", "clock period", v, 20);
  endtask

  task automatic t_interval();
    int n = 0;
    wr(8'h10, 32'd5);
    wr(8'h00, 32'h0400_0000);
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      check(pulse_c == (i % 5 == 0), "R3", $sformatf("pulse in cycle %0d", i), pulse_c, (i % 5 == 0));
      if (pulse_c) n++;
    end
    check(n == 4, "R3", "pulse count over 20 cycles", n, 4);
  endtask

  task automatic t_count();
    logic [31:0] c0, c1;
    rd(8'h14, c0);
    for (int k = 0; k < 6; k++) begin
      rd(8'h14, c1);
      check(c1 == (c0 + 1) % 5 && c1 < 5, "R4", "count step", c1, (c0 + 1) % 5);
      c0 = c1;
    end
  endtask

  task automatic t_stop();
    logic [31:0] v;
    int n = 0;
    wr(8'h00, 32'h0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pulse_c) n++;
    end
    check(n == 0, "R5", "pulses while stopped", n, 0);
    rd(8'h14, v); check(v == 0, "R5", "count while stopped", v, 0);
  endtask

  task automatic t_zero_limit();
    int n = 0;
    wr(8'h10, 32'd0);
    wr(8'h00, 32'h0400_0000);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pulse_c) n++;
    end
    check(n == 0, "R6", "pulses with zero interval", n, 0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_irq_map();
    // number 0xC5, priority 0xA: compact = 0x40 | 0x05 | 0x28 = 0x6D
    wr(8'h10, 32'd3);
    wr(8'h00, 32'h04AC_5000);
    @(negedge clk);
    check(num_c == 0 && prio_c == 0, "R7", "outputs idle between pulses", {num_c, prio_c}, 0);
    @(negedge clk);
    @(negedge clk);
    check(pulse_c == 1, "R7", "pulse present", pulse_c, 1);
    check(num_c == 8'h6D, "R7", "compact number", num_c, 8'h6D);
    check(prio_c == 4'hA, "R7", "compact priority", prio_c, 4'hA);
    check(num_p == 8'hC5, "R7", "plain number", num_p, 8'hC5);
    check(prio_p == 4'hA, "R7", "plain priority", prio_p, 4'hA);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_ns_wrap();
    logic [31:0] v, s0;
    wr(8'h24, 32'd100);
    rd(8'h28, s0);
    rd(8'h28, v); check(v == s0 + 20, "R9", "step per clock", v, s0 + 20);
    wr(8'h28, 32'd999_999_970);
    rd(8'h28, v); check(v == 32'd999_999_970, "R11", "nanoseconds load", v, 32'd999_999_970);
    rd(8'h28, v); check(v == 32'd999_999_990, "R9", "before wrap", v, 32'd999_999_990);
    rd(8'h28, v); check(v == 32'd10, "R9", "after wrap", v, 32'd10);
    rd(8'h24, v); check(v == 32'd101, "R10", "seconds low carry", v, 32'd101);
  endtask

  task automatic t_sec_carry();
    logic [31:0] v;
    wr(8'h20, 32'd5);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h28, 32'd999_999_960);
    rd(8'h28, v); check(v == 32'd999_999_960, "R11", "nanoseconds load", v, 32'd999_999_960);
    rd(8'h24, v); check(v == 32'hFFFF_FFFF, "R11", "seconds low load", v, 32'hFFFF_FFFF);
    rd(8'h28, v); check(v == 32'd0, "R9", "exact wrap to zero", v, 0);
    rd(8'h24, v); check(v == 32'd0, "R10", "seconds low same-edge carry", v, 0);
    rd(8'h20, v); check(v == 32'd6, "R10", "carry into seconds high", v, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_interval();
    t_count();
    t_stop();
    t_zero_limit();
    t_irq_map();
    t_ns_wrap();
    t_sec_carry();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule